// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Compare

This block holds a 16-bit counter and two 16-bit compare channels, A and B. An 8-bit CPU register bus reaches all of them one byte at a time. A single shared holding byte keeps each 16-bit transfer atomic:

- **Reads:** reading the counter's low byte freezes its high half in the holding byte.
- **Writes:** writing any high byte parks the value in the holding byte. The following low-byte write then commits both halves in one clock.

The counter advances on each clock in which the `tick` enable is high. It counts upward in normal mode. In symmetric mode it runs up and down, turning at both ends.

Each channel raises a sticky interrupt flag when the counter arrives at the channel's compare value by counting. Software writes that merely make the two values equal never raise a flag. Software clears a flag by writing 1 to its bit in a status byte.

Top module: `byte_timer16`

## Requirements
- R1: A read of the counter low byte (address 0x2C) returns the live low byte. On the same clock it copies the live high byte into the holding byte. A read of the counter high byte (0x2D) returns the holding byte, not the live counter.
- R2: A write to a compare high byte (A: 0x2B, B: 0x29) changes only the holding byte. A write to the matching low byte (A: 0x2A, B: 0x28) loads {holding byte, written byte} into the 16-bit register in one clock. A read of either compare byte returns the committed register value directly.
- R3: One holding byte serves the counter and both compare registers. The most recent high-byte write or counter low-byte read to any of them decides what the next low-byte write commits.
- R4: A write to the counter low byte (0x2C) loads {holding byte, written byte} into the counter. The counter does not advance on that clock even if `tick` is high, and it resumes on the next clock with `tick` high. With `tick` low and no write, the counter holds.
- R5: A write to the counter or to a compare register that makes the two equal raises no compare flag.
- R6: When the counter steps to a channel's compare value, the compare event lies in the cycle after that step. The flag becomes 1 on the clock edge after the event, so it reads 0 in the event cycle and 1 one cycle later.
- R7: With `pwm_mode` low, each tick adds one, and 0xFFFF is followed by 0x0000.
- R8: With `pwm_mode` high, the counter reverses at 0xFFFF (next value 0xFFFE) and at 0x0000 (next value 0x0001). Each end value appears once per turn.
- R9: The status byte at 0x38 shows flag A at bit 4 and flag B at bit 3, with all other bits 0. Writing 1 to a bit clears that flag, and writing 0 leaves it. A set and a clear on the same clock leave the flag set.
- R10: After reset the counter, both compare registers and both flags are 0, and the direction is upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the selected clock source |
| pwm_mode | input | 1 | 1 selects up/down counting |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (has side effects on the holding byte) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| flag_a | output | 1 | Compare A interrupt flag |
| flag_b | output | 1 | Compare B interrupt flag |

## Verification
The bench targets the following corner cases:

- **Split reads.** It reads the counter in two halves with a step in between. A design that fed the high byte live would return the post-step value.
- **Shared holding byte.** It interleaves high-byte writes to different registers. A design with a holding byte per register would commit the stale value.
- **Preset while counting.** It presets the counter with `tick` running. A design that counted on the write edge would read one too high.
- **Flag timing.** It makes the values equal by software from both sides, then arrives by counting. It checks that the flag is still 0 in the event cycle, and it clears on the exact set edge. An early, software-triggered or clear-dominant flag each shows up.
- **Turning points.** It steps across 0xFFFF and 0x0000 in both modes. A repeated end value or a missing wrap fails the step-by-step readback.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the byte-accessed timer.
// Assumes an 8-bit bus address space; only the decoded offsets below respond.
package tmr_pkg;
    localparam int BUS_DW = 8;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] ADR_CMPB_LO = 8'h28;
    localparam logic [BUS_AW-1:0] ADR_CMPB_HI = 8'h29;
    localparam logic [BUS_AW-1:0] ADR_CMPA_LO = 8'h2A;
    localparam logic [BUS_AW-1:0] ADR_CMPA_HI = 8'h2B;
    localparam logic [BUS_AW-1:0] ADR_CNT_LO  = 8'h2C;
    localparam logic [BUS_AW-1:0] ADR_CNT_HI  = 8'h2D;
    localparam logic [BUS_AW-1:0] ADR_STATUS  = 8'h38;

    localparam int FLAG_A_BIT = 4;
    localparam int FLAG_B_BIT = 3;

    typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/tmr_regs.sv
// Bus decode, shared holding byte and the two compare registers.
// Assumes at most one of wr/rd is active per cycle; write takes priority.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = BUS_DW,
    parameter int AW = BUS_AW,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] cnt,
    input  logic          flag_a,
    input  logic          flag_b,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] hold,
    output logic [CW-1:0] cmp_a,
    output logic [CW-1:0] cmp_b,
    output logic          cnt_ld,
    output logic          cmp_a_ld,
    output logic          cmp_b_ld,
    output logic [CW-1:0] ld_val,
    output logic          clr_a,
    output logic          clr_b
);
    logic hi_wr;
    logic cnt_lo_rd;

    // Decode strobes for each register access.
    always_comb begin
        hi_wr     = wr && (addr == ADR_CNT_HI || addr == ADR_CMPA_HI || addr == ADR_CMPB_HI);
        cnt_lo_rd = rd && !wr && (addr == ADR_CNT_LO);
        cnt_ld    = wr && (addr == ADR_CNT_LO);
        cmp_a_ld  = wr && (addr == ADR_CMPA_LO);
        cmp_b_ld  = wr && (addr == ADR_CMPB_LO);
        ld_val    = {hold, wdata};
        clr_a     = wr && (addr == ADR_STATUS) && wdata[FLAG_A_BIT];
        clr_b     = wr && (addr == ADR_STATUS) && wdata[FLAG_B_BIT];
    end

    // Holding byte: loaded by high-byte writes and by counter low reads.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= '0;
        else if (hi_wr)     hold <= wdata;
        else if (cnt_lo_rd) hold <= cnt[CW-1:DW];
    end

    // Compare registers commit both halves on the low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a <= '0;
            cmp_b <= '0;
        end else begin
            if (cmp_a_ld) cmp_a <= ld_val;
            if (cmp_b_ld) cmp_b <= ld_val;
        end
    end

    // Read mux; compare bytes come straight from the committed registers.
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_CNT_LO:  rdata = cnt[DW-1:0];
            ADR_CNT_HI:  rdata = hold;
            ADR_CMPA_LO: rdata = cmp_a[DW-1:0];
            ADR_CMPA_HI: rdata = cmp_a[CW-1:DW];
            ADR_CMPB_LO: rdata = cmp_b[DW-1:0];
            ADR_CMPB_HI: rdata = cmp_b[CW-1:DW];
            ADR_STATUS: begin
                rdata[FLAG_A_BIT] = flag_a;
                rdata[FLAG_B_BIT] = flag_b;
            end
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
// Counter core: preset has priority over counting; up or up/down stepping.
// Assumes tick is a one-cycle enable already synchronous to clk.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    localparam logic [CW-1:0] TOP = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pwm_mode,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt
);
    dir_e dir;

    // Advance, turn or preset the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (tick) begin
            if (!pwm_mode) begin
                cnt <= cnt + CW'(1);
                dir <= DIR_UP;
            end else if (dir == DIR_UP) begin
                if (cnt == TOP) begin
                    cnt <= TOP - CW'(1);
                    dir <= DIR_DOWN;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                if (cnt == '0) begin
                    cnt <= CW'(1);
                    dir <= DIR_UP;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tmr_cmp_flag.sv
// One compare channel: detects arrival by counting and keeps a sticky flag.
// Assumes 'stepped' means the counter advanced (not preset) on this edge.
module tmr_cmp_flag #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stepped,
    input  logic          cmp_ld,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          clr,
    output logic          flag
);
    logic armed;
    logic hit;

    // Armed only after a counting step that left this register untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= stepped && !cmp_ld;
    end

    // Compare event in the cycle following the step.
    always_comb hit = armed && (cnt == cmp);

    // Sticky flag; a set beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/byte_timer16.sv
// Top: 16-bit timer with two compare channels on an 8-bit register bus.
// Assumes the bus issues one access per cycle and that tick is synchronous.
module byte_timer16
    import tmr_pkg::*;
#(
    parameter int DW = BUS_DW,
    parameter int AW = BUS_AW,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pwm_mode,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          flag_a,
    output logic          flag_b
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cmp_a;
    logic [CW-1:0] cmp_b;
    logic [CW-1:0] ld_val;
    logic [DW-1:0] hold;
    logic          cnt_ld;
    logic          cmp_a_ld;
    logic          cmp_b_ld;
    logic          clr_a;
    logic          clr_b;
    logic          stepped;

    // A counting step happens only when ticking and not presetting.
    always_comb stepped = tick && !cnt_ld;

    tmr_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt), .flag_a(flag_a), .flag_b(flag_b),
        .rdata(bus_rdata), .hold(hold), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cnt_ld(cnt_ld), .cmp_a_ld(cmp_a_ld), .cmp_b_ld(cmp_b_ld),
        .ld_val(ld_val), .clr_a(clr_a), .clr_b(clr_b)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_mode(pwm_mode),
        .ld(cnt_ld), .ld_val(ld_val), .cnt(cnt)
    );

    tmr_cmp_flag #(.CW(CW)) u_ch_a (
        .clk(clk), .rst_n(rst_n), .stepped(stepped), .cmp_ld(cmp_a_ld),
        .cnt(cnt), .cmp(cmp_a), .clr(clr_a), .flag(flag_a)
    );

    tmr_cmp_flag #(.CW(CW)) u_ch_b (
        .clk(clk), .rst_n(rst_n), .stepped(stepped), .cmp_ld(cmp_b_ld),
        .cnt(cnt), .cmp(cmp_b), .clr(clr_b), .flag(flag_b)
    );
endmodule

// File: rtl/byte_timer16_chk.sv
// Checker for byte_timer16, attached by bind below.
module byte_timer16_chk
    import tmr_pkg::*;
#(
    parameter int DW = BUS_DW,
    parameter int AW = BUS_AW,
    localparam int CW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          pwm_mode,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] cmp_a,
    input logic [DW-1:0] hold,
    input logic          flag_a
);
    logic cnt_wr;
    always_comb cnt_wr = bus_wr && (bus_addr == ADR_CNT_LO);

    // R4
    cnt_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == {$past(hold), $past(bus_wdata)});

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    // R7
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pwm_mode && !cnt_wr) |=> cnt == $past(cnt) + CW'(1));

    // R8
    top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pwm_mode && !cnt_wr && cnt == '1) |=> cnt == {{(CW-1){1'b1}}, 1'b0});

    // R8
    bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pwm_mode && !cnt_wr && cnt == '0) |=> cnt == CW'(1));

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(cnt == cmp_a));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_STATUS && bus_wdata[FLAG_A_BIT] && cnt != cmp_a)
        |=> !flag_a);
endmodule

bind byte_timer16 byte_timer16_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_mode(pwm_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt(cnt), .cmp_a(cmp_a), .hold(hold), .flag_a(flag_a)
);

// File: tb/test_byte_timer16.sv
module test_byte_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pwm_mode = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       flag_a;
    logic       flag_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CBL = 8'h28, A_CBH = 8'h29, A_CAL = 8'h2A, A_CAH = 8'h2B;
    localparam logic [7:0] A_CNL = 8'h2C, A_CNH = 8'h2D, A_ST = 8'h38;

    always #4 clk = ~clk;

    byte_timer16 i_byte_timer16 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_mode(pwm_mode),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic write16(input logic [7:0] hi_a, input logic [7:0] lo_a, input logic [15:0] v);
        bus_write(hi_a, v[15:8]);
        bus_write(lo_a, v[7:0]);
    endtask

    task automatic read_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(A_CNL, lo);
        bus_read(A_CNH, hi);
        v = {hi, lo};
    endtask

    task automatic tick_pulse();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [15:0] v;
        bus_read(A_CAL, d); check("R10 cmpA lo", d, 0);
        bus_read(A_CBH, d); check("R10 cmpB hi", d, 0);
        bus_read(A_ST, d);  check("R10 status", d, 0);
        read_cnt(v);        check("R10 counter", v, 0);
        pwm_mode = 1'b1;
        tick_pulse();
        read_cnt(v);        check("R10 direction up", v, 16'h0001);
        pwm_mode = 1'b0;
    endtask

    task automatic t_cmp_regs();
        logic [7:0] d;
        write16(A_CAH, A_CAL, 16'hA55A);
        bus_write(A_CAH, 8'h77);
        bus_read(A_CAH, d); check("R2 high-only write keeps A", d, 8'hA5);
        bus_write(A_CAL, 8'h11);
        bus_read(A_CAH, d); check("R2 commit A hi", d, 8'h77);
        bus_read(A_CAL, d); check("R2 commit A lo", d, 8'h11);
        write16(A_CBH, A_CBL, 16'hBEEF);
        bus_read(A_CBL, d); check("R2 B lo", d, 8'hEF);
        bus_read(A_CBH, d); check("R2 B hi", d, 8'hBE);
    endtask

    task automatic t_shared_hold();
        logic [7:0] d;
        bus_write(A_CAH, 8'h12);
        bus_write(A_CBH, 8'h34);
        bus_write(A_CAL, 8'h56);
        bus_read(A_CAH, d); check("R3 shared byte into A", d, 8'h34);
        write16(A_CNH, A_CNL, 16'h9900);
        bus_read(A_CNL, d);
        bus_write(A_CBL, 8'h01);
        bus_read(A_CBH, d); check("R3 counter read feeds B", d, 8'h99);
    endtask

    task automatic t_atomic_read();
        logic [7:0] d;
        write16(A_CNH, A_CNL, 16'h12FF);
        bus_read(A_CNL, d); check("R1 live low", d, 8'hFF);
        tick_pulse();
        bus_read(A_CNH, d); check("R1 frozen high", d, 8'h12);
        bus_read(A_CNL, d); check("R1 low after step", d, 8'h00);
        bus_read(A_CNH, d); check("R1 new high", d, 8'h13);
    endtask

    task automatic t_preset();
        logic [7:0] d;
        logic [15:0] v;
        tick = 1'b1;
        bus_write(A_CNH, 8'h01);
        bus_write(A_CNL, 8'h00);
        bus_read(A_CNL, d); check("R4 no step on write edge", d, 8'h00);
        bus_read(A_CNL, d); check("R4 resumes next tick", d, 8'h01);
        tick = 1'b0;
        repeat (3) @(negedge clk);
        read_cnt(v);        check("R4 hold without tick", v, 16'h0102);
    endtask

    task automatic t_no_sw_match();
        bus_write(A_ST, 8'h18);
        write16(A_CAH, A_CAL, 16'h0050);
        write16(A_CNH, A_CNL, 16'h0050);
        repeat (3) @(negedge clk);
        check("R5 counter write equal", flag_a, 0);
        write16(A_CBH, A_CBL, 16'h0050);
        repeat (3) @(negedge clk);
        check("R5 compare write equal", flag_b, 0);
    endtask

    task automatic t_match_timing();
        write16(A_CAH, A_CAL, 16'h0070);
        write16(A_CBH, A_CBL, 16'h0080);
        write16(A_CNH, A_CNL, 16'h006F);
        bus_write(A_ST, 8'h18);
        tick_pulse();
        check("R6 flag not yet in event cycle", flag_a, 0);
        @(negedge clk);
        check("R6 flag one cycle later", flag_a, 1);
        check("R6 other channel quiet", flag_b, 0);
    endtask

    task automatic t_status();
        logic [7:0] d;
        bus_read(A_ST, d); check("R9 status bit4", d, 8'h10);
        bus_write(A_ST, 8'h08);
        check("R9 zero bit keeps A", flag_a, 1);
        bus_write(A_ST, 8'h10);
        check("R9 clear A", flag_a, 0);
        tick_pulse();
        tick_pulse();
        write16(A_CNH, A_CNL, 16'h007F);
        tick_pulse();
        bus_write(A_ST, 8'h08);
        check("R9 set wins over clear", flag_b, 1);
        bus_read(A_ST, d); check("R9 status bit3", d, 8'h08);
        bus_write(A_ST, 8'h08);
        check("R9 clear B", flag_b, 0);
    endtask

    task automatic t_updown();
        logic [15:0] v;
        pwm_mode = 1'b1;
        write16(A_CNH, A_CNL, 16'hFFFE);
        tick_pulse(); read_cnt(v); check("R8 reach top", v, 16'hFFFF);
        tick_pulse(); read_cnt(v); check("R8 turn at top", v, 16'hFFFE);
        tick_pulse(); read_cnt(v); check("R8 descend", v, 16'hFFFD);
        write16(A_CNH, A_CNL, 16'h0002);
        tick_pulse(); read_cnt(v); check("R8 down kept after preset", v, 16'h0001);
        tick_pulse(); read_cnt(v); check("R8 reach bottom", v, 16'h0000);
        tick_pulse(); read_cnt(v); check("R8 turn at bottom", v, 16'h0001);
        tick_pulse(); read_cnt(v); check("R8 ascend", v, 16'h0002);
        pwm_mode = 1'b0;
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        write16(A_CNH, A_CNL, 16'hFFFF);
        tick_pulse(); read_cnt(v); check("R7 wrap to zero", v, 16'h0000);
        tick_pulse(); read_cnt(v); check("R7 count up", v, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmp_regs();
        t_shared_hold();
        t_atomic_read();
        t_preset();
        t_no_sw_match();
        t_match_timing();
        t_status();
        t_updown();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule